// File: doc/BRIEF.md
# Processor Power State Controller

This block follows the power-management state of one processor core through four states: Working, Halt, Stop Grant and Probe. A halt-instruction strobe from the core takes it from Working into Halt and sends a single-cycle halt special-cycle request to the system bus. Once the system logic reports that the processor bus is disconnected, Halt also raises a low-power enable. Halt ends on any wake event. The active-low stop-clock request moves the block into Stop Grant. From Stop Grant, a snoop-probe request takes it into a one-cycle Probe state, where a service strobe is raised.

The controller only tracks state. It never gates the system clock, and it assumes that clock runs in every state. Instruction execution, snoop servicing and clock generation happen elsewhere; they read the state and strobes driven here. All inputs are sampled on the rising clock edge. Every state change becomes visible on `state_o` one cycle after the inputs that cause it.

Top module: `pwr_state_ctrl`

## Requirements
- R1: In Working, `halt_i` high with `stpclk_ni` high and `wake_reset_i` low moves `state_o` to Halt (1) on the next cycle. `halt_cyc_o` is high for exactly that one cycle.
- R2: `lowpwr_o` is high only while `state_o` is Halt and `bus_disc_i` is high. It is low in every other case.
- R3: In Halt, with `stpclk_ni` high, any one of `wake_init_i`, `wake_smi_i`, `wake_intr_i`, `wake_nmi_i` or `wake_lapic_i` returns `state_o` to Working (0) on the next cycle. Without a wake event the block stays in Halt.
- R4: `stpclk_ni` low in Working or Halt moves `state_o` to Stop Grant (2) on the next cycle. This takes priority over a halt strobe or a wake event in the same cycle.
- R5: In Stop Grant, with `stpclk_ni` high and no probe request, the block returns to Working on the next cycle. With `stpclk_ni` low and no probe request, it stays in Stop Grant.
- R6: In Stop Grant, `probe_req_i` high moves `state_o` to Probe (3) on the next cycle, even if `stpclk_ni` is released in the same cycle. `probe_svc_o` is high exactly while `state_o` is Probe.
- R7: Probe lasts one cycle. It goes back to Stop Grant if `stpclk_ni` is low, and to Working if `stpclk_ni` is high.
- R8: `stpg_ack_o` is high for exactly the first cycle in Stop Grant after entry from Working or Halt. It stays low on a return from Probe.
- R9: `wake_reset_i` high forces Working on the next cycle from any state, over every other input.
- R10: `probe_req_i` has no effect in Working or Halt.
- R11: `rst_ni` low asynchronously forces Working, and all strobes and `lowpwr_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, never gated |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Halt-instruction strobe from the core |
| stpclk_ni | input | 1 | Stop-clock request, active low |
| probe_req_i | input | 1 | Snoop-probe request |
| bus_disc_i | input | 1 | System logic reports the processor bus disconnected |
| wake_init_i | input | 1 | INIT wake event |
| wake_reset_i | input | 1 | RESET wake event, synchronous, forces Working |
| wake_smi_i | input | 1 | SMI wake event |
| wake_intr_i | input | 1 | INTR wake event |
| wake_nmi_i | input | 1 | NMI wake event |
| wake_lapic_i | input | 1 | Local interrupt message wake event |
| state_o | output | 2 | Current state: 0 Working, 1 Halt, 2 Stop Grant, 3 Probe |
| halt_cyc_o | output | 1 | One-cycle halt special-cycle request to the system bus |
| lowpwr_o | output | 1 | Low-power enable in Halt |
| probe_svc_o | output | 1 | Probe-service strobe |
| stpg_ack_o | output | 1 | One-cycle stop-grant acknowledge |

## Verification
Two functions can fall in the same cycle and compete. The first is a stop-clock assertion against a wake event or halt strobe; the second is a probe request against release of the stop-clock. Directed steps drive each pair together: an interrupt with `stpclk_ni` low while in Halt, and `probe_req_i` with `stpclk_ni` rising while in Stop Grant. Random stimulus with biased input rates then produces many more such collisions. A bench model applies the stated priorities and decides the expected state, acknowledge and strobes for every cycle.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  typedef enum logic [1:0] {
    ST_WORK  = 2'd0,
    ST_HALT  = 2'd1,
    ST_STOPG = 2'd2,
    ST_PROBE = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pwr_wake_merge.sv
module pwr_wake_merge #(
  parameter int NUM_SRC = 5
) (
  input  logic [NUM_SRC-1:0] src_i,
  output logic               wake_o
);
  logic [NUM_SRC:0] chain;
  assign chain[0] = 1'b0;
  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_or
    assign chain[gi+1] = chain[gi] | src_i[gi];
  end
  assign wake_o = chain[NUM_SRC];
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_state_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_i,
  input  logic       stp_req_i,
  input  logic       probe_req_i,
  input  logic       wake_i,
  input  logic       sys_rst_i,
  output pwr_state_e state_o,
  output logic       halt_cyc_o,
  output logic       stpg_ack_o
);
  pwr_state_e st_q, st_d;
  logic       halt_cyc_q, stpg_ack_q;

  always_comb begin
    st_d = st_q;
    if (sys_rst_i) begin
      st_d = ST_WORK;
    end else begin
      unique case (st_q)
        ST_WORK:  if (stp_req_i) st_d = ST_STOPG;
                  else if (halt_i) st_d = ST_HALT;
        ST_HALT:  if (stp_req_i) st_d = ST_STOPG;
                  else if (wake_i) st_d = ST_WORK;
        // probe wins over release so no request is dropped
        ST_STOPG: if (probe_req_i) st_d = ST_PROBE;
                  else if (!stp_req_i) st_d = ST_WORK;
        ST_PROBE: st_d = stp_req_i ? ST_STOPG : ST_WORK;
        default:  st_d = ST_WORK;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_WORK;
      halt_cyc_q <= 1'b0;
      stpg_ack_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      halt_cyc_q <= (st_q == ST_WORK) && (st_d == ST_HALT);
      stpg_ack_q <= (st_d == ST_STOPG) && (st_q inside {ST_WORK, ST_HALT});
    end
  end

  assign state_o    = st_q;
  assign halt_cyc_o = halt_cyc_q;
  assign stpg_ack_o = stpg_ack_q;

  AST_HALT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WORK && halt_i && !stp_req_i && !sys_rst_i) |=> (st_q == ST_HALT && halt_cyc_q)); // R1
  AST_HALT_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HALT && wake_i && !stp_req_i) |=> (st_q == ST_WORK)); // R3
  AST_STPCLK_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stp_req_i && !sys_rst_i) |=> (st_q inside {ST_STOPG, ST_PROBE})); // R4
  AST_PROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PROBE) |=> (st_q != ST_PROBE)); // R7
  AST_ACK_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stpg_ack_q |-> (st_q == ST_STOPG && $past(st_q) != ST_STOPG && $past(st_q) != ST_PROBE)); // R8
  AST_SYNC_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i |=> (st_q == ST_WORK && !stpg_ack_q && !halt_cyc_q)); // R9
  AST_PROBE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q inside {ST_WORK, ST_HALT}) |=> (st_q != ST_PROBE)); // R10
endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
  import pwr_state_pkg::*;
(
  input  pwr_state_e state_i,
  input  logic       bus_disc_i,
  output logic       lowpwr_o,
  output logic       probe_svc_o
);
  assign lowpwr_o    = (state_i == ST_HALT) && bus_disc_i;
  assign probe_svc_o = (state_i == ST_PROBE);
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  localparam int NUM_WAKE = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_i,
  input  logic       stpclk_ni,
  input  logic       probe_req_i,
  input  logic       bus_disc_i,
  input  logic       wake_init_i,
  input  logic       wake_reset_i,
  input  logic       wake_smi_i,
  input  logic       wake_intr_i,
  input  logic       wake_nmi_i,
  input  logic       wake_lapic_i,
  output logic [1:0] state_o,
  output logic       halt_cyc_o,
  output logic       lowpwr_o,
  output logic       probe_svc_o,
  output logic       stpg_ack_o
);
  pwr_state_e st;
  logic       wake_any;

  pwr_wake_merge #(.NUM_SRC(NUM_WAKE)) u_wake (
    .src_i  ({wake_init_i, wake_smi_i, wake_intr_i, wake_nmi_i, wake_lapic_i}),
    .wake_o (wake_any)
  );

  pwr_state_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .halt_i      (halt_i),
    .stp_req_i   (!stpclk_ni),
    .probe_req_i (probe_req_i),
    .wake_i      (wake_any),
    .sys_rst_i   (wake_reset_i),
    .state_o     (st),
    .halt_cyc_o  (halt_cyc_o),
    .stpg_ack_o  (stpg_ack_o)
  );

  pwr_out_decode u_out (
    .state_i     (st),
    .bus_disc_i  (bus_disc_i),
    .lowpwr_o    (lowpwr_o),
    .probe_svc_o (probe_svc_o)
  );

  assign state_o = st;

  AST_LOWPWR_HALT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowpwr_o |-> (u_fsm.st_q == ST_HALT)); // R2
  AST_PROBE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_svc_o |-> ($past(state_o) == 2'd2 && $past(probe_req_i))); // R6
endmodule

// File: tb/pwr_state_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_state_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic halt_i = 0, stpclk_ni = 1, probe_req_i = 0, bus_disc_i = 0;
  logic wake_init_i = 0, wake_reset_i = 0, wake_smi_i = 0;
  logic wake_intr_i = 0, wake_nmi_i = 0, wake_lapic_i = 0;
  logic [1:0] state_o;
  logic halt_cyc_o, lowpwr_o, probe_svc_o, stpg_ack_o;

  int checks = 0, failures = 0;
  logic [1:0] m_st = 2'd0;
  logic m_hc = 0, m_ack = 0;
  string tag = "R11";

  always #5 clk = ~clk;

  pwr_state_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .halt_i(halt_i), .stpclk_ni(stpclk_ni),
    .probe_req_i(probe_req_i), .bus_disc_i(bus_disc_i),
    .wake_init_i(wake_init_i), .wake_reset_i(wake_reset_i), .wake_smi_i(wake_smi_i),
    .wake_intr_i(wake_intr_i), .wake_nmi_i(wake_nmi_i), .wake_lapic_i(wake_lapic_i),
    .state_o(state_o), .halt_cyc_o(halt_cyc_o), .lowpwr_o(lowpwr_o),
    .probe_svc_o(probe_svc_o), .stpg_ack_o(stpg_ack_o)
  );

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string t);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(state_o, m_st, tag);
    chk({1'b0, halt_cyc_o}, {1'b0, m_hc}, "R1 halt_cyc");
    chk({1'b0, stpg_ack_o}, {1'b0, m_ack}, "R8 stpg_ack");
    chk({1'b0, probe_svc_o}, {1'b0, m_st == 2'd3}, "R6 probe_svc");
    chk({1'b0, lowpwr_o}, {1'b0, m_st == 2'd1 && bus_disc_i}, "R2 lowpwr");
  endtask

  function automatic logic any_wake();
    return wake_init_i | wake_smi_i | wake_intr_i | wake_nmi_i | wake_lapic_i;
  endfunction

  // model next state from stated priorities
  task automatic step();
    logic [1:0] nx;
    @(posedge clk);
    nx = m_st;
    if (wake_reset_i) begin nx = 2'd0; tag = "R9"; end
    else case (m_st)
      2'd0: if (!stpclk_ni) begin nx = 2'd2; tag = "R4"; end
            else if (halt_i) begin nx = 2'd1; tag = "R1"; end
            else tag = "R10";
      2'd1: if (!stpclk_ni) begin nx = 2'd2; tag = "R4"; end
            else if (any_wake()) begin nx = 2'd0; tag = "R3"; end
            else tag = "R10";
      2'd2: if (probe_req_i) begin nx = 2'd3; tag = "R6"; end
            else if (stpclk_ni) begin nx = 2'd0; tag = "R5"; end
            else tag = "R5";
      default: begin nx = stpclk_ni ? 2'd0 : 2'd2; tag = "R7"; end
    endcase
    m_hc  = (m_st == 2'd0) && (nx == 2'd1);
    m_ack = (nx == 2'd2) && (m_st == 2'd0 || m_st == 2'd1);
    m_st  = nx;
    @(negedge clk);
    check_all();
  endtask

  task automatic clr();
    halt_i = 0; stpclk_ni = 1; probe_req_i = 0;
    wake_init_i = 0; wake_reset_i = 0; wake_smi_i = 0;
    wake_intr_i = 0; wake_nmi_i = 0; wake_lapic_i = 0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (2) @(negedge clk);
    tag = "R11"; check_all();
    rst_ni = 1;
    step();
    // R1 halt entry and single special cycle
    halt_i = 1; step(); halt_i = 0; step();
    // R2 low power only with bus disconnected; R10 probe ignored in Halt
    bus_disc_i = 1; step(); probe_req_i = 1; step(); probe_req_i = 0;
    // R4 stop-clock beats wake in Halt
    wake_intr_i = 1; stpclk_ni = 0; step(); wake_intr_i = 0;
    // R6 probe, R7 back to Stop Grant, R8 no ack on return
    probe_req_i = 1; step(); probe_req_i = 0; step();
    // R6 probe beats release, R7 to Working
    probe_req_i = 1; stpclk_ni = 1; step(); probe_req_i = 0; step();
    // R5 release from Stop Grant
    stpclk_ni = 0; step(); stpclk_ni = 1; step();
    // R3 each wake source
    for (int k = 0; k < 5; k++) begin
      halt_i = 1; step(); halt_i = 0;
      case (k)
        0: wake_init_i = 1; 1: wake_smi_i = 1; 2: wake_intr_i = 1;
        3: wake_nmi_i = 1; default: wake_lapic_i = 1;
      endcase
      step(); clr();
    end
    // R10 probe ignored in Working
    probe_req_i = 1; step(); probe_req_i = 0;
    // R9 reset beats stop-clock
    stpclk_ni = 0; step(); wake_reset_i = 1; step(); clr(); step();
    // R11 asynchronous reset mid Stop Grant
    stpclk_ni = 0; step();
    #2 rst_ni = 0; #1;
    m_st = 0; m_hc = 0; m_ack = 0; tag = "R11";
    check_all();
    @(negedge clk); rst_ni = 1; clr(); step();
    // random mix
    for (int i = 0; i < 4000; i++) begin
      halt_i       = ($urandom_range(0, 3) == 0);
      stpclk_ni    = ($urandom_range(0, 9) > 2);
      probe_req_i  = ($urandom_range(0, 2) == 0);
      bus_disc_i   = $urandom_range(0, 1);
      wake_init_i  = ($urandom_range(0, 15) == 0);
      wake_smi_i   = ($urandom_range(0, 15) == 0);
      wake_intr_i  = ($urandom_range(0, 15) == 0);
      wake_nmi_i   = ($urandom_range(0, 15) == 0);
      wake_lapic_i = ($urandom_range(0, 15) == 0);
      wake_reset_i = ($urandom_range(0, 49) == 0);
      step();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule